// File: doc/BRIEF.md
# Glitch-free programmable clock output

This block derives an auxiliary clock from the main clock. A 3-bit setting held inside the block picks the output. The output can be the main clock itself, the main clock divided by 2, 3, 4 or 8, or a constant low. The output stays low after power-on until a start-up timer has run out. A ready flag tells the rest of the chip when that has happened.

Changing the setting never produces a shortened pulse. A new setting is taken up only at the end of a low phase. The output is then forced low for a short gap before the new ratio starts.

The setting survives the ordinary reset and goes back to divide-by-4 only on power-on reset. A power-down request leaves the output running. It drops the ready flag and restarts the start-up timer.

Top module: `clkout_gen`

## Requirements
- R1: After power-on reset the setting reads back 3'b100 (divide by 4), `clk_rdy` is 0 and `clk_out` is low. Once started, the output runs at divide-by-4 until the setting is written.
- R2: After power-on reset is released, `clk_rdy` rises at the `STARTUP_CYC`-th rising clock edge. `clk_out` stays low up to and including that edge.
- R3: In steady state the setting codes give the following high/low phase lengths, in main-clock cycles: 3'b001 follows the main clock; 3'b010 is 1/1; 3'b011 is 1 high then 2 low; 3'b100 is 2/2; 3'b101 is 4/4.
- R4: Codes 3'b000, 3'b110 and 3'b111 hold `clk_out` constantly low.
- R5: A new setting is taken up only after the current output phase has returned low. The output then stays low for a further `GAP_CYC` cycles, with 2 <= `GAP_CYC` <= 8. No high or low pulse is shorter than the shorter of the old and new ratios' phases.
- R6: While `rst_n` is low, `clk_rdy`, the stored setting and the running output are unaffected, and setting writes are ignored.
- R7: While `pdown` is high, `clk_rdy` is 0 and `clk_out` keeps running. After `pdown` falls, `clk_rdy` rises again at the `STARTUP_CYC`-th rising edge.
- R8: `cfg_rdata` returns the last accepted 3-bit write, including the reserved codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Ordinary reset, active low; blocks setting writes only |
| pdown | input | 1 | Power-down request |
| cfg_we | input | 1 | Setting write strobe |
| cfg_wdata | input | 3 | Setting write value |
| cfg_rdata | output | 3 | Stored setting |
| clk_rdy | output | 1 | Start-up timer has expired |
| clk_out | output | 1 | Generated clock |

## Verification
The bench builds the block with `STARTUP_CYC` = 24 and `GAP_CYC` = 3. The short timer lets it check the exact edge at which readiness rises, both after power-on and after power-down, and still have room to exercise every setting. The short gap means a reconfiguration settles within a few periods of divide-by-8. Each transition's low stretch is therefore measured in full, and so are the shortest pulses on either side of it.

// File: rtl/clkout_gen.sv
module clkout_gen #(
  parameter int STARTUP_CYC = 7500,
  parameter int GAP_CYC     = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       pdown,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  output logic [2:0] cfg_rdata,
  output logic       clk_rdy,
  output logic       clk_out
);

  localparam int OST_W = $clog2(STARTUP_CYC + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [1:0] S_HOLD = 2'd0;
  localparam logic [1:0] S_GAP  = 2'd1;
  localparam logic [1:0] S_RUN  = 2'd2;

  function automatic logic [2:0] norm(input logic [2:0] c);
    return (c >= 3'd6) ? 3'd0 : c;
  endfunction

  function automatic logic [3:0] per_len(input logic [2:0] c);
    case (c)
      3'd2:    return 4'd2;
      3'd3:    return 4'd3;
      3'd4:    return 4'd4;
      3'd5:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] hi_len(input logic [2:0] c);
    case (c)
      3'd2:    return 4'd1;
      3'd3:    return 4'd1;
      3'd4:    return 4'd2;
      3'd5:    return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  logic [2:0]       cfg_q;
  logic [OST_W-1:0] ost_cnt;
  logic             rdy, live;
  logic [1:0]       state, n_state;
  logic [2:0]       cur, n_cur;
  logic [3:0]       cnt, n_cnt;
  logic [GAP_W-1:0] gap_cnt, n_gap;
  logic             out_q, gate_d, gate_l;
  logic             pend, boundary;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                cfg_q <= 3'd4;
    else if (cfg_we && rst_n)  cfg_q <= cfg_wdata;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ost_cnt <= '0;
      rdy     <= 1'b0;
      live    <= 1'b0;
    end else if (pdown) begin
      ost_cnt <= '0;
      rdy     <= 1'b0;
    end else if (!rdy) begin
      if (ost_cnt == OST_W'(STARTUP_CYC - 1)) begin
        rdy     <= 1'b1;
        live    <= 1'b1;
        ost_cnt <= '0;
      end else begin
        ost_cnt <= ost_cnt + 1'b1;
      end
    end
  end

  assign pend     = norm(cfg_q) != cur;
  assign boundary = cnt == per_len(cur) - 4'd1;

  always_comb begin
    n_state = state;
    n_cur   = cur;
    n_cnt   = cnt;
    n_gap   = gap_cnt;
    case (state)
      S_HOLD:
        if (live) begin
          n_state = S_RUN;
          n_cur   = norm(cfg_q);
          n_cnt   = '0;
        end
      S_GAP:
        if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
          n_state = S_RUN;
          n_cur   = norm(cfg_q);
          n_cnt   = '0;
          n_gap   = '0;
        end else begin
          n_gap = gap_cnt + 1'b1;
        end
      default:
        if (boundary) begin
          n_cnt = '0;
          if (pend) begin
            n_state = S_GAP;
            n_gap   = '0;
          end
        end else begin
          n_cnt = cnt + 4'd1;
        end
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state   <= S_HOLD;
      cur     <= 3'd0;
      cnt     <= '0;
      gap_cnt <= '0;
      out_q   <= 1'b0;
      gate_d  <= 1'b0;
    end else begin
      state   <= n_state;
      cur     <= n_cur;
      cnt     <= n_cnt;
      gap_cnt <= n_gap;
      out_q   <= (n_state == S_RUN) && (n_cnt < hi_len(n_cur));
      gate_d  <= (n_state == S_RUN) && (n_cur == 3'd1);
    end
  end

  // gate enable only changes while the clock is low
  always_latch
    if (!por_n)    gate_l = 1'b0;
    else if (!clk) gate_l = gate_d;

  assign clk_out   = (clk & gate_l) | out_q;
  assign clk_rdy   = rdy;
  assign cfg_rdata = cfg_q;

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       pdown,
  input logic       rdy,
  input logic       live,
  input logic [1:0] state,
  input logic [2:0] cur,
  input logic [2:0] cfg_q,
  input logic       out_q,
  input logic       gate_d
);

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!por_n)
    !live |-> (!out_q && !gate_d));

  p_start_after_ready_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(live) |-> rdy);

  p_gap_quiet_r5: assert property (@(posedge clk) disable iff (!por_n)
    (state == 2'd1) |-> (!out_q && !gate_d));

  p_change_at_low_r5: assert property (@(posedge clk) disable iff (!por_n)
    (state == 2'd2 && out_q) |=> (state != 2'd1));

  p_div3_single_high_r3: assert property (@(posedge clk) disable iff (!por_n)
    (state == 2'd2 && cur == 3'd3 && out_q) |=> !out_q);

  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    (rdy && !pdown) |=> rdy);

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> $stable(cfg_q));

  p_pdown_clears_r7: assert property (@(posedge clk) disable iff (!por_n)
    pdown |=> !rdy);

  p_output_stays_live_r7: assert property (@(posedge clk) disable iff (!por_n)
    live |=> live);

endmodule

bind clkout_gen clkout_gen_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .pdown(pdown), .rdy(rdy),
  .live(live), .state(state), .cur(cur), .cfg_q(cfg_q), .out_q(out_q),
  .gate_d(gate_d)
);

// File: tb/clkout_gen_tb_top.sv
module clkout_gen_tb_top;

  localparam int STARTUP = 24;
  localparam int GAP     = 3;
  localparam int NVEC    = 11;
  // {code, expected high half-cycles, expected low half-cycles}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd1, 5'd1, 5'd1}, {3'd2, 5'd2, 5'd2}, {3'd3, 5'd2, 5'd4},
    {3'd5, 5'd8, 5'd8}, {3'd0, 5'd0, 5'd0}, {3'd6, 5'd0, 5'd0},
    {3'd7, 5'd0, 5'd0}, {3'd3, 5'd2, 5'd4}, {3'd4, 5'd4, 5'd4},
    {3'd1, 5'd1, 5'd1}, {3'd5, 5'd8, 5'd8}
  };

  logic clk = 1'b0;
  logic por_n, rst_n, pdown, cfg_we;
  logic [2:0] cfg_wdata, cfg_rdata;
  logic clk_rdy, clk_out;

  int n_chk = 0, n_err = 0;
  bit cur_v = 1'b0, valid = 1'b0;
  int run = 0, min_hi, max_hi, min_lo, max_lo, n_rise, hi_total;

  always #5 clk = ~clk;

  clkout_gen #(.STARTUP_CYC(STARTUP), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .pdown(pdown),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .clk_rdy(clk_rdy), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    valid = 1'b0; run = 0; n_rise = 0; hi_total = 0;
    min_hi = 999; max_hi = 0; min_lo = 999; max_lo = 0;
  endtask

  task automatic mon_sample(input bit v);
    if (v) hi_total++;
    if (v && !cur_v) n_rise++;
    if (v == cur_v) run++;
    else begin
      if (valid) begin
        if (cur_v) begin
          if (run < min_hi) min_hi = run;
          if (run > max_hi) max_hi = run;
        end else begin
          if (run < min_lo) min_lo = run;
          if (run > max_lo) max_lo = run;
        end
      end
      valid = 1'b1;
      run = 1;
    end
    cur_v = v;
  endtask

  always begin
    @(posedge clk);
    #2 mon_sample(clk_out);
    #5 mon_sample(clk_out);
  end

  task automatic write_cfg(input logic [2:0] c);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_wdata = c;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_steady(input string tag, input int eh, input int el);
    if (eh == 0) begin
      chk(n_rise == 0, tag, n_rise, 0);
      chk(hi_total == 0, tag, hi_total, 0);
    end else begin
      chk(max_hi == eh, tag, max_hi, eh);
      chk(min_hi == eh, tag, min_hi, eh);
      chk(max_lo == el, tag, max_lo, el);
      chk(min_lo == el, tag, min_lo, el);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int ph, pl;
    por_n = 1'b0; rst_n = 1'b1; pdown = 1'b0; cfg_we = 1'b0; cfg_wdata = 3'd0;
    mon_clear();
    repeat (3) @(posedge clk);
    #7;
    chk(clk_rdy == 1'b0, "R1 ready at reset", int'(clk_rdy), 0);
    chk(cfg_rdata == 3'd4, "R1 default setting", int'(cfg_rdata), 4);
    chk(clk_out == 1'b0, "R1 output at reset", int'(clk_out), 0);

    @(posedge clk); #5 por_n = 1'b1; mon_clear();
    repeat (STARTUP - 1) @(posedge clk);
    #7;
    chk(clk_rdy == 1'b0, "R2 ready before expiry", int'(clk_rdy), 0);
    @(posedge clk); #7;
    chk(clk_rdy == 1'b1, "R2 ready at expiry", int'(clk_rdy), 1);
    chk(hi_total == 0, "R2 output low until expiry", hi_total, 0);
    wait_cyc(40); mon_clear(); wait_cyc(40);
    check_steady("R1 default divide by 4", 4, 4);

    ph = 4; pl = 4;
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] code;
      int eh, el, mh, ml;
      code = VEC[i][12:10];
      eh = int'(VEC[i][9:5]);
      el = int'(VEC[i][4:0]);
      mon_clear();
      write_cfg(code);
      wait_cyc(40);
      if (ph != 0 || eh != 0) begin
        mh = (ph == 0) ? eh : (eh == 0) ? ph : ((ph < eh) ? ph : eh);
        ml = (pl == 0) ? el : (el == 0) ? pl : ((pl < el) ? pl : el);
        if (min_hi != 999) chk(min_hi >= mh, "R5 no short high pulse", min_hi, mh);
        if (min_lo != 999 && ml != 0) chk(min_lo >= ml, "R5 no short low pulse", min_lo, ml);
        if (ph != 0 && eh != 0)
          chk(max_lo >= 2 * GAP - 1, "R5 low gap on change", max_lo, 2 * GAP - 1);
      end
      mon_clear(); wait_cyc(40);
      if (eh == 0) check_steady("R4 disabled code", 0, 0);
      else         check_steady("R3 divide ratio", eh, el);
      chk(cfg_rdata == code, "R8 setting readback", int'(cfg_rdata), int'(code));
      ph = eh; pl = el;
    end

    write_cfg(3'd2); wait_cyc(40);
    mon_clear();
    @(posedge clk); #1 rst_n = 1'b0; cfg_we = 1'b1; cfg_wdata = 3'd5;
    @(posedge clk); #1 cfg_we = 1'b0;
    wait_cyc(20);
    rst_n = 1'b1;
    chk(cfg_rdata == 3'd2, "R6 write ignored in reset", int'(cfg_rdata), 2);
    chk(clk_rdy == 1'b1, "R6 ready kept", int'(clk_rdy), 1);
    chk(n_rise >= 8, "R6 output kept running", n_rise, 8);
    chk(max_hi == 2 && min_hi == 2, "R6 ratio kept", max_hi, 2);

    mon_clear();
    @(posedge clk); #1 pdown = 1'b1;
    @(posedge clk); #6;
    chk(clk_rdy == 1'b0, "R7 ready drops", int'(clk_rdy), 0);
    wait_cyc(20);
    chk(n_rise >= 8, "R7 output runs in power-down", n_rise, 8);
    @(posedge clk); #1 pdown = 1'b0;
    repeat (STARTUP - 1) @(posedge clk);
    #6;
    chk(clk_rdy == 1'b0, "R7 ready before restart expiry", int'(clk_rdy), 0);
    @(posedge clk); #6;
    chk(clk_rdy == 1'b1, "R7 ready after restart", int'(clk_rdy), 1);

    write_cfg(3'd3); wait_cyc(5);
    @(posedge clk); #1 por_n = 1'b0;
    @(posedge clk); #6;
    chk(cfg_rdata == 3'd4, "R1 setting back to default", int'(cfg_rdata), 4);
    chk(clk_rdy == 1'b0, "R1 ready cleared", int'(clk_rdy), 0);
    chk(clk_out == 1'b0, "R1 output low in reset", int'(clk_out), 0);
    #4 chk(clk_out == 1'b0, "R1 output low in reset high phase", int'(clk_out), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule